// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches one tearing-effect line from a display panel. Horizontal and vertical sync both arrive on that line, and the block tells them apart by pulse width. Widths are measured in enabled ticks. A pulse that reaches the vertical threshold is taken as a frame start and resets a line counter. A shorter pulse that still reaches the horizontal threshold advances the counter by one line. A pulse too short for either threshold is discarded.

Depending on the programmed mode, the block raises a one-cycle match event on every frame start or when a chosen line is reached after a frame start. An active-low interrupt copy follows one cycle later, so a falling-edge interrupt input can release exactly one pending frame write. This keeps the write clear of the panel's scan position. The pin is asynchronous and passes through a two-flop synchroniser first. Each sync kind has its own polarity-inversion control.

Top module: `te_sync_detect`

## Requirements
- R1: The panel pin is synchronised by two flops. If the pin returns inactive just before rising edge E, `match_pulse` is high exactly during the cycle that begins at edge E+2, and is low again after edge E+3.
- R2: A pulse's width is the number of cycles with `tick_en` high while the synchronised pin is active. Cycles with `tick_en` low do not add to the width.
- R3: A pulse is classified as vertical sync when its width is at least (`vs_width_code`+1)*8 ticks. For example, code 1 gives 16 ticks. A vertical sync sets the line count to zero and arms line matching.
- R4: A pulse is classified as horizontal sync when its width is at least `hs_width_code`+1 ticks and below the vertical threshold. The largest 3-bit code, 7, gives 8 ticks. Each horizontal sync adds one line. A narrower pulse is ignored.
- R5: `hs_invert` and `vs_invert` select the active level: 0 means active high and 1 means active low. A pulse at the inverted level is detected in the same way.
- R6: In mode 3 (frame-only), every vertical sync produces one match.
- R7: In mode 2 (line mode) with `target_line` 0, every vertical sync produces one match.
- R8: In mode 2 with `target_line` N > 0, one match occurs on the horizontal sync that makes the line count N after a vertical sync. Horizontal syncs before the first vertical sync never match.
- R9: Mode 0 (off), mode 1 (reserved), or `detect_en` low produce no match.
- R10: `irq_n` is high out of reset and goes low for the one cycle that follows each `match_pulse` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| te_pin | input | 1 | Asynchronous tearing-effect line from the panel |
| tick_en | input | 1 | Width-measurement tick enable |
| detect_en | input | 1 | Master enable of the detection logic |
| mode | input | 2 | 0 off, 1 reserved (off), 2 line mode, 3 frame-only |
| hs_width_code | input | 3 | Horizontal sync minimum width, ticks minus one |
| vs_width_code | input | 12 | Vertical sync minimum width, units of 8 ticks minus one |
| hs_invert | input | 1 | Horizontal sync is active low when set |
| vs_invert | input | 1 | Vertical sync is active low when set |
| target_line | input | 11 | Line to match in line mode; 0 selects the frame start |
| match_pulse | output | 1 | One-cycle match event |
| irq_n | output | 1 | Active-low interrupt, one cycle after the match |

## Verification
The pulse classifier is driven with patterns on both sides of each threshold: 15 against 16 ticks for the vertical level, 2 against 3 ticks, and 7 against 8 ticks at the capped horizontal level. These patterns separate a correct comparison from an off-by-one error or a strict-versus-inclusive mistake. The table of frame-plus-line sequences exercises every mode with different target lines and line counts. It shows whether matching depends on the mode, on the count reached, and on a vertical sync being seen first. A gated tick pattern shows whether widths count ticks rather than cycles. An inverted-level run and a directed cycle-exact latency test fix the polarity logic and the register chain.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

  localparam int HS_CODE_W = 3;
  localparam int VS_CODE_W = 12;
  localparam int CNT_W     = VS_CODE_W + 4;
  localparam int LINE_W    = 11;

  typedef enum logic [1:0] {
    TE_OFF    = 2'd0,
    TE_RSVD   = 2'd1,
    TE_LINE   = 2'd2,
    TE_FRAME  = 2'd3
  } te_mode_e;

  // minimum horizontal width in ticks
  function automatic logic [CNT_W-1:0] hs_limit(input logic [HS_CODE_W-1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  // minimum vertical width in ticks, code counts groups of eight
  function automatic logic [CNT_W-1:0] vs_limit(input logic [VS_CODE_W-1:0] code);
    return (CNT_W'(code) + CNT_W'(1)) << 3;
  endfunction

  // saturating line step
  function automatic logic [LINE_W-1:0] line_step(input logic [LINE_W-1:0] cnt);
    return (&cnt) ? cnt : cnt + LINE_W'(1);
  endfunction

endpackage

// File: rtl/te_sync2.sv
module te_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter
  import te_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             invert,
  input  logic             tick_en,
  output logic             done,
  output logic [CNT_W-1:0] width
);
  logic             act, act_q, in_pulse, rise, fall;
  logic [CNT_W-1:0] cnt;

  assign act  = sync_in ^ invert;
  assign rise = act & ~act_q;
  assign fall = ~act & act_q;

  // act_q resets to 1 so a pin already active at reset never opens a pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b1;
      in_pulse <= 1'b0;
      cnt      <= '0;
    end else begin
      act_q <= act;
      if (rise) begin
        in_pulse <= 1'b1;
        cnt      <= tick_en ? CNT_W'(1) : '0;
      end else if (act) begin
        if (tick_en && !(&cnt)) cnt <= cnt + CNT_W'(1);
      end else begin
        in_pulse <= 1'b0;
        cnt      <= '0;
      end
    end
  end

  assign done  = fall & in_pulse;
  assign width = cnt;

  assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && act_q && !tick_en) |=> (cnt == $past(cnt)) || !act);
endmodule

// File: rtl/te_line_match.sv
module te_line_match
  import te_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_evt,
  input  logic              hs_evt,
  input  logic              detect_en,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] target_line,
  output logic              match_pulse,
  output logic              irq_n
);
  logic [LINE_W-1:0] line_cnt, next_line;
  logic              armed, hit;
  te_mode_e          m;

  assign m         = te_mode_e'(mode);
  assign next_line = line_step(line_cnt);

  always_comb begin
    hit = 1'b0;
    if (detect_en) begin
      unique case (m)
        TE_FRAME: hit = vs_evt;
        TE_LINE:  hit = (target_line == '0) ? vs_evt
                                            : (hs_evt && armed && next_line == target_line);
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt    <= '0;
      armed       <= 1'b0;
      match_pulse <= 1'b0;
      irq_n       <= 1'b1;
    end else begin
      if (vs_evt) begin
        line_cnt <= '0;
        armed    <= 1'b1;
      end else if (hs_evt) begin
        line_cnt <= next_line;
      end
      match_pulse <= hit;
      irq_n       <= ~match_pulse;
    end
  end

  assert_vs_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vs_evt |=> (line_cnt == '0) && armed);
  assert_hs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_evt && !vs_evt && !(&line_cnt)) |=> line_cnt == $past(line_cnt) + LINE_W'(1));
  assert_frame_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_en && mode == 2'd3 && vs_evt) |=> match_pulse);
  assert_line0_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_en && mode == 2'd2 && target_line == '0 && vs_evt) |=> match_pulse);
  assert_unarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && mode == 2'd2 && target_line != '0) |=> !match_pulse);
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!detect_en || mode[1] == 1'b0) |=> !match_pulse);
  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !irq_n);
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_sync_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 te_pin,
  input  logic                 tick_en,
  input  logic                 detect_en,
  input  logic [1:0]           mode,
  input  logic [HS_CODE_W-1:0] hs_width_code,
  input  logic [VS_CODE_W-1:0] vs_width_code,
  input  logic                 hs_invert,
  input  logic                 vs_invert,
  input  logic [LINE_W-1:0]    target_line,
  output logic                 match_pulse,
  output logic                 irq_n
);
  logic             pin_s;
  logic [1:0]       done;
  logic [CNT_W-1:0] width [2];
  logic             vs_evt, hs_evt;
  logic [CNT_W-1:0] hs_min, vs_min;

  te_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(te_pin), .q(pin_s)
  );

  // channel 0 measures at the horizontal polarity, channel 1 at the vertical one
  for (genvar g = 0; g < 2; g++) begin : g_meter
    te_pulse_meter u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (pin_s),
      .invert  ((g == 0) ? hs_invert : vs_invert),
      .tick_en (tick_en),
      .done    (done[g]),
      .width   (width[g])
    );
  end

  assign hs_min = hs_limit(hs_width_code);
  assign vs_min = vs_limit(vs_width_code);
  assign vs_evt = done[1] && (width[1] >= vs_min);
  assign hs_evt = done[0] && (width[0] >= hs_min) && (width[0] < vs_min);

  te_line_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .vs_evt      (vs_evt),
    .hs_evt      (hs_evt),
    .detect_en   (detect_en),
    .mode        (mode),
    .target_line (target_line),
    .match_pulse (match_pulse),
    .irq_n       (irq_n)
  );

  assert_class_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vs_evt, hs_evt}));
  assert_short_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && width[0] < hs_min && !vs_evt) |=> u_match.line_cnt == $past(u_match.line_cnt));
endmodule

// File: tb/test_te_sync_detect.sv
`timescale 1ns/1ps
module test_te_sync_detect;
  logic        clk = 1'b0, rst_n = 1'b0, te_pin = 1'b0;
  logic        tick_en = 1'b1, detect_en = 1'b1, hs_inv = 1'b0, vs_inv = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic [2:0]  hs_code = 3'd2;
  logic [11:0] vs_code = 12'd1;
  logic [10:0] target = '0;
  logic        match_pulse, irq_n;
  logic        tick_gate = 1'b0;
  int          checks = 0, errors = 0, mcount = 0;
  bit          done_flag = 1'b0;

  te_sync_detect i_te_sync_detect (
    .clk(clk), .rst_n(rst_n), .te_pin(te_pin), .tick_en(tick_en),
    .detect_en(detect_en), .mode(mode), .hs_width_code(hs_code),
    .vs_width_code(vs_code), .hs_invert(hs_inv), .vs_invert(vs_inv),
    .target_line(target), .match_pulse(match_pulse), .irq_n(irq_n)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (match_pulse) mcount++;
    tick_en <= tick_gate ? ~tick_en : 1'b1;
  end

  localparam int NROW = 8;
  localparam logic [1:0]  T_MODE [NROW] = '{2'd3, 2'd2, 2'd2, 2'd2, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [10:0] T_LINE [NROW] = '{11'd0, 11'd0, 11'd2, 11'd5, 11'd0, 11'd2, 11'd1, 11'd0};
  localparam int          T_NHS  [NROW] = '{4, 3, 4, 3, 3, 3, 0, 0};

  function automatic int expect_matches(logic [1:0] md, logic [10:0] ln, int nhs);
    if (md == 2'd3) return 1;
    if (md == 2'd2) return (ln == 0) ? 1 : ((int'(ln) <= nhs) ? 1 : 0);
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // active level is the opposite of the idle level (idle = hs_inv)
  task automatic pulse(int n);
    @(negedge clk);
    te_pin = ~hs_inv;
    repeat (n) @(negedge clk);
    te_pin = hs_inv;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    check(irq_n === 1'b1, "R10 reset irq_n", int'(irq_n), 1);
    check(match_pulse === 1'b0, "R10 reset match", int'(match_pulse), 0);

    // R1 / R10: exact latency of a frame-only match
    @(negedge clk); te_pin = 1'b1;
    repeat (20) @(negedge clk);
    te_pin = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check(match_pulse === 1'b1, "R1 match at E+2", int'(match_pulse), 1);
    check(irq_n === 1'b1, "R10 irq before", int'(irq_n), 1);
    @(posedge clk); #1;
    check(match_pulse === 1'b0, "R1 match one cycle", int'(match_pulse), 0);
    check(irq_n === 1'b0, "R10 irq low", int'(irq_n), 0);
    @(posedge clk); #1;
    check(irq_n === 1'b1, "R10 irq release", int'(irq_n), 1);

    // table: one frame pulse then N line pulses, count matches (R6 R7 R8 R9)
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      mode = T_MODE[r]; target = T_LINE[r]; mcount = 0;
      pulse(24);
      for (int h = 0; h < T_NHS[r]; h++) pulse(3);
      check(mcount == expect_matches(T_MODE[r], T_LINE[r], T_NHS[r]),
            $sformatf("R6/R7/R8/R9 row %0d", r), mcount,
            expect_matches(T_MODE[r], T_LINE[r], T_NHS[r]));
    end

    // R3 threshold boundary at 16 ticks
    mode = 2'd3; mcount = 0; pulse(16);
    check(mcount == 1, "R3 width 16 is frame", mcount, 1);
    mcount = 0; pulse(15);
    check(mcount == 0, "R3 width 15 not frame", mcount, 0);
    vs_code = 12'd3; mcount = 0; pulse(24);
    check(mcount == 0, "R3 width 24 below 32", mcount, 0);
    vs_code = 12'd1;

    // R4 horizontal boundaries
    mode = 2'd2; target = 11'd1;
    mcount = 0; pulse(24); pulse(2);
    check(mcount == 0, "R4 width 2 ignored", mcount, 0);
    pulse(3);
    check(mcount == 1, "R4 width 3 counts line", mcount, 1);
    mcount = 0; pulse(24); pulse(15);
    check(mcount == 1, "R4 width 15 is line", mcount, 1);
    hs_code = 3'd7;
    mcount = 0; pulse(24); pulse(7);
    check(mcount == 0, "R4 capped width 7 ignored", mcount, 0);
    pulse(8);
    check(mcount == 1, "R4 capped width 8 counts", mcount, 1);
    hs_code = 3'd2;

    // R8 no match before any frame pulse
    do_reset();
    mode = 2'd2; target = 11'd1; mcount = 0;
    pulse(3); pulse(3);
    check(mcount == 0, "R8 unarmed lines", mcount, 0);

    // R9 master enable low
    mode = 2'd3; detect_en = 1'b0; mcount = 0; pulse(24);
    check(mcount == 0, "R9 enable low", mcount, 0);
    detect_en = 1'b1;

    // R2 gated ticks: half the cycles tick
    tick_gate = 1'b1; mcount = 0; pulse(24);
    check(mcount == 0, "R2 24 cycles is 12 ticks", mcount, 0);
    mcount = 0; pulse(40);
    check(mcount == 1, "R2 40 cycles is 20 ticks", mcount, 1);
    tick_gate = 1'b0;
    repeat (2) @(negedge clk);

    // R5 inverted polarity, pin idles high
    hs_inv = 1'b1; vs_inv = 1'b1; te_pin = 1'b1;
    do_reset();
    mcount = 0; repeat (10) @(negedge clk);
    check(mcount == 0, "R5 idle high quiet", mcount, 0);
    pulse(24);
    check(mcount == 1, "R5 low pulse is frame", mcount, 1);
    mode = 2'd2; target = 11'd2; mcount = 0;
    pulse(24); pulse(4); pulse(4);
    check(mcount == 1, "R5 low line pulses", mcount, 1);

    finish_run();
  end
endmodule